// File: doc/BRIEF.md
# Instruction Translation Buffer with Pseudo-LRU Refill

This block is a four-entry translation buffer that sits between the instruction fetch path and a larger unified translation buffer. Each fetch address is compared against all four entries in parallel. The comparison follows each entry's page size, its valid bit and its address-space identifier. On a single hit the block returns the physical address. It also updates a six-bit replacement code and checks whether user-mode execution is allowed.

When no entry matches, the block asks the unified buffer for the translation over a simple request/response interface. A failure reported by the unified buffer is passed straight through as the result. A successful answer is written into the slot named by the replacement code, and the lookup runs once more. Fetches in the unmapped kernel regions, and all fetches while translation is switched off, pass through untranslated. A user-mode fetch from the top region of the address space is rejected.

Top module: `itlb_top`

## Requirements
- R1: When `xlat_on` is 0, or bits 31:29 of the fetch address are 100, 101 or 111, the result is status 0 (ok) with `res_paddr` equal to the fetch address, and no unified-buffer request is made.
- R2: A user-mode fetch (`mode_user`=1) from an address whose bits 31:29 are 111 gives status 4 (address error). This check takes priority over R1.
- R3: An entry matches when it is valid and its page number equals the address above the page boundary. Size code 0 gives 1 KiB pages, 1 gives 4 KiB, 2 gives 64 KiB and 3 gives 1 MiB. The physical address is the entry's frame bits above the boundary joined with the fetch address bits below it.
- R4: The address-space identifier is compared only for non-shared entries, and only when the fetch is in user mode or `priv_skip_asid` is 0. Otherwise it is ignored.
- R5: If two or more entries match, the result is status 2 (multi-hit).
- R6: On a miss, `utlb_req` stays high with `utlb_vaddr` until `utlb_resp_valid`. A response status of 1 gives status 1 (miss) and a response status of 2 gives status 2. A failed response writes no entry.
- R7: A successful response is written into the victim slot and the lookup is retried once. If the retry still misses, the result is status 1. Each fetch makes at most one unified-buffer request.
- R8: The replacement code resets to 0, which names slot 3. A hit on slot e sets the code to (code AND A[e]) OR O[e], with A = 07,39,3E,3F and O = 00,20,14,0B (hex). The victim is slot 0 when bits 5:3 are 111. It is slot 1 when bit 5 is 0 and bits 2:1 are 11. It is slot 2 when bits 4 and 2 are 0 and bit 0 is 1. It is slot 3 when bits 3, 1 and 0 are 0. Together these rules always evict the least recently used slot.
- R9: A single hit on an entry whose `pr` bit 1 is 0, during a user-mode fetch, gives status 3 (protection).
- R10: A fetch is accepted while `fetch_ready` is high. `res_valid` is a one-cycle pulse. For a bypassed or rejected fetch, it rises on the second clock edge counted from the accepting edge.
- R11: After reset `res_valid` and `utlb_req` are low, `fetch_ready` is high and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch translation request |
| fetch_ready | output | 1 | Block idle and able to accept a fetch |
| fetch_vaddr | input | 32 | Virtual fetch address |
| mode_user | input | 1 | 1 = user mode, 0 = privileged |
| xlat_on | input | 1 | Address translation enable |
| priv_skip_asid | input | 1 | Privileged fetches ignore the identifier |
| cur_asid | input | 8 | Current address-space identifier |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Physical address (0 unless status is 0) |
| res_status | output | 3 | 0 ok, 1 miss, 2 multi-hit, 3 protection, 4 address error |
| utlb_req | output | 1 | Unified-buffer lookup request |
| utlb_vaddr | output | 32 | Address to look up |
| utlb_resp_valid | input | 1 | Unified-buffer response valid |
| utlb_resp_status | input | 2 | 0 ok, 1 miss, 2 multi-hit |
| utlb_vpn | input | 22 | Returned page number |
| utlb_asid | input | 8 | Returned identifier |
| utlb_ppn | input | 22 | Returned frame number |
| utlb_size | input | 2 | Returned size code |
| utlb_shared | input | 1 | Returned shared flag |
| utlb_pr | input | 2 | Returned protection bits |

## Verification
The bench builds the block with the default 32-bit address, the 10-bit minimum page offset and the 8-bit identifier. These settings make every size code, every bypass region and the user-mode top region reachable with ordinary addresses. A stand-in unified buffer in the bench answers each request after a short delay. Its frame numbers, sizes, protection bits and failure codes can be chosen per test, and it can return a deliberately wrong page to force a failing retry. Eviction order is observed at the ports: the bench counts how many unified-buffer requests each fetch causes.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  parameter int VA_W   = 32;
  parameter int ASID_W = 8;
  parameter int PG_LSB = 10;
  parameter int VPN_W  = VA_W - PG_LSB;
  parameter int WAYS   = 4;
  parameter int WAY_W  = $clog2(WAYS);
  parameter int CNT_W  = $clog2(WAYS + 1);
  parameter int LRU_W  = 6;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_MISS  = 3'd1,
    ST_MULTI = 3'd2,
    ST_PROT  = 3'd3,
    ST_ADDR  = 3'd4
  } xl_status_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic              shared;
    logic [1:0]        pr;
  } tlb_ent_t;

  // Mask that keeps the address bits above the page boundary
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] size);
    logic [VA_W-1:0] m;
    m = '1;
    case (size)
      2'd0:    m = m << 10;
      2'd1:    m = m << 12;
      2'd2:    m = m << 16;
      default: m = m << 20;
    endcase
    return m;
  endfunction

  function automatic logic [LRU_W-1:0] lru_keep(input logic [WAY_W-1:0] way);
    case (way)
      2'd0:    return 6'h07;
      2'd1:    return 6'h39;
      2'd2:    return 6'h3E;
      default: return 6'h3F;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_set(input logic [WAY_W-1:0] way);
    case (way)
      2'd0:    return 6'h00;
      2'd1:    return 6'h20;
      2'd2:    return 6'h14;
      default: return 6'h0B;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_next(input logic [LRU_W-1:0] code,
                                                input logic [WAY_W-1:0] way);
    return (code & lru_keep(way)) | lru_set(way);
  endfunction

  // One bit per slot: that slot is older than every other slot
  function automatic logic [WAYS-1:0] lru_oldest(input logic [LRU_W-1:0] code);
    logic [WAYS-1:0] v;
    logic [LRU_W-1:0] key;
    for (int e = 0; e < WAYS; e++) begin
      key  = ~lru_keep(WAY_W'(e));
      v[e] = ((code & (key | lru_set(WAY_W'(e)))) == key);
    end
    return v;
  endfunction

  function automatic logic in_bypass_region(input logic [VA_W-1:0] va);
    return (va[VA_W-1 -: 2] == 2'b10) || (va[VA_W-1 -: 3] == 3'b111);
  endfunction
endpackage

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
(
  input  tlb_ent_t          ents [WAYS],
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic              user,
  input  logic              skip_asid,
  output logic [WAYS-1:0]   hit_vec,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [WAY_W-1:0]  hit_idx,
  output logic [VA_W-1:0]   hit_pa
);
  logic [VA_W-1:0] pa_way [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [VA_W-1:0] mask;
    logic            page_eq;
    logic            need_id;
    assign mask    = page_mask(ents[g].size);
    assign page_eq = (({ents[g].vpn, {PG_LSB{1'b0}}} & mask) == (va & mask));
    assign need_id = !ents[g].shared && (user || !skip_asid);
    assign hit_vec[g] = ents[g].valid && page_eq && (!need_id || ents[g].asid == asid);
    assign pa_way[g]  = ({ents[g].ppn, {PG_LSB{1'b0}}} & mask) | (va & ~mask);
  end

  always_comb begin
    hit_cnt = '0;
    hit_idx = '0;
    hit_pa  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) begin
        hit_cnt = hit_cnt + 1'b1;
        hit_idx = WAY_W'(i);
        hit_pa  = pa_way[i];
      end
    end
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_idx,
  output logic [WAY_W-1:0] victim
);
  logic [LRU_W-1:0] code_q;
  logic [WAYS-1:0]  oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (touch) code_q <= lru_next(code_q, touch_idx);
  end

  assign oldest = lru_oldest(code_q);

  always_comb begin
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (oldest[i]) victim = WAY_W'(i);
  end

  // R8: the code reached by updates always names exactly one victim
  p_one_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

  // R8: a slot just touched is never the next victim
  p_touched_not_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (victim != $past(touch_idx)));
endmodule

// File: rtl/itlb_top.sv
module itlb_top
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [VA_W-1:0]   fetch_vaddr,
  input  logic              mode_user,
  input  logic              xlat_on,
  input  logic              priv_skip_asid,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              res_valid,
  output logic [VA_W-1:0]   res_paddr,
  output logic [2:0]        res_status,
  output logic              utlb_req,
  output logic [VA_W-1:0]   utlb_vaddr,
  input  logic              utlb_resp_valid,
  input  logic [1:0]        utlb_resp_status,
  input  logic [VPN_W-1:0]  utlb_vpn,
  input  logic [ASID_W-1:0] utlb_asid,
  input  logic [VPN_W-1:0]  utlb_ppn,
  input  logic [1:0]        utlb_size,
  input  logic              utlb_shared,
  input  logic [1:0]        utlb_pr
);
  typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_REFILL, S_RETRY, S_DONE} fsm_e;

  fsm_e              st_q, st_d;
  tlb_ent_t          ents_q [WAYS];
  logic [VA_W-1:0]   va_q, pa_q, pa_d;
  xl_status_e        res_q, res_d;
  logic              user_q, at_q, skip_q, retried_q;
  logic [ASID_W-1:0] asid_q;

  logic [WAYS-1:0]   hit_vec;
  logic [CNT_W-1:0]  hit_cnt;
  logic [WAY_W-1:0]  hit_idx, victim;
  logic [VA_W-1:0]   hit_pa;

  // Named internal events
  logic bypass_w, addr_err_w, prot_w, touch_w, refill_ok_w, accept_w;

  itlb_match u_match (
    .ents(ents_q), .va(va_q), .asid(asid_q), .user(user_q), .skip_asid(skip_q),
    .hit_vec(hit_vec), .hit_cnt(hit_cnt), .hit_idx(hit_idx), .hit_pa(hit_pa)
  );

  itlb_lru u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch_w), .touch_idx(hit_idx), .victim(victim)
  );

  assign accept_w    = (st_q == S_IDLE) && fetch_valid;
  assign bypass_w    = !at_q || in_bypass_region(va_q);
  assign addr_err_w  = user_q && (va_q[VA_W-1 -: 3] == 3'b111);
  assign prot_w      = user_q && !ents_q[hit_idx].pr[1];
  assign refill_ok_w = (st_q == S_REFILL) && utlb_resp_valid && (utlb_resp_status == 2'd0);

  always_comb begin
    st_d    = st_q;
    res_d   = res_q;
    pa_d    = pa_q;
    touch_w = 1'b0;
    case (st_q)
      S_IDLE: if (fetch_valid) st_d = S_LOOKUP;
      S_LOOKUP: begin
        st_d = S_DONE;
        pa_d = '0;
        if (addr_err_w) res_d = ST_ADDR;
        else if (bypass_w) begin
          res_d = ST_OK;
          pa_d  = va_q;
        end else if (hit_cnt == '0) begin
          if (retried_q) res_d = ST_MISS;
          else           st_d  = S_REFILL;
        end else if (hit_cnt > CNT_W'(1)) res_d = ST_MULTI;
        else begin
          touch_w = 1'b1;
          if (prot_w) res_d = ST_PROT;
          else begin
            res_d = ST_OK;
            pa_d  = hit_pa;
          end
        end
      end
      S_REFILL: if (utlb_resp_valid) begin
        if (utlb_resp_status == 2'd0) st_d = S_RETRY;
        else begin
          st_d  = S_DONE;
          pa_d  = '0;
          res_d = (utlb_resp_status == 2'd2) ? ST_MULTI : ST_MISS;
        end
      end
      S_RETRY: st_d = S_LOOKUP;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      res_q     <= ST_OK;
      pa_q      <= '0;
      va_q      <= '0;
      user_q    <= 1'b0;
      at_q      <= 1'b0;
      skip_q    <= 1'b0;
      asid_q    <= '0;
      retried_q <= 1'b0;
      for (int i = 0; i < WAYS; i++) ents_q[i] <= '0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      pa_q  <= pa_d;
      if (accept_w) begin
        va_q      <= fetch_vaddr;
        user_q    <= mode_user;
        at_q      <= xlat_on;
        skip_q    <= priv_skip_asid;
        asid_q    <= cur_asid;
        retried_q <= 1'b0;
      end
      if (refill_ok_w) begin
        ents_q[victim] <= '{valid: 1'b1, vpn: utlb_vpn, asid: utlb_asid, ppn: utlb_ppn,
                            size: utlb_size, shared: utlb_shared, pr: utlb_pr};
        retried_q      <= 1'b1;
      end
    end
  end

  assign fetch_ready = (st_q == S_IDLE);
  assign res_valid   = (st_q == S_DONE);
  assign res_paddr   = pa_q;
  assign res_status  = res_q;
  assign utlb_req    = (st_q == S_REFILL);
  assign utlb_vaddr  = va_q;

  // R1: a bypassed fetch never raises a unified-buffer request
  p_bypass_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOOKUP && bypass_w) |=> !utlb_req);

  // R2: an address error is only ever reported for a user-mode fetch
  p_addr_err_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_ADDR) |-> user_q);

  // R6: the request is held until answered
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_req && !utlb_resp_valid) |=> (utlb_req && $stable(utlb_vaddr)));

  // R7: at most one refill per fetch
  p_single_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_req |-> !retried_q);

  // R9: protection faults only come from user-mode fetches
  p_prot_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_PROT) |-> user_q);

  // R10: result is a single-cycle pulse
  p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: the pipeline never reports ok from a multi-match lookup
  p_multi_not_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOOKUP && !bypass_w && !addr_err_w && hit_cnt > CNT_W'(1))
      |=> (res_status == ST_MULTI));
endmodule

// File: tb/itlb_top_test.sv
module itlb_top_test;
  localparam logic [21:0] KEY = 22'h155555;

  typedef struct packed {
    logic [31:0] va;
    logic        user;
    logic        at;
    logic [2:0]  st;
    logic [3:0]  refills;
  } vec_t;

  // Default stand-in config: 4 KiB pages, pr=3, shared
  localparam vec_t VEC [11] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 3'd0, 4'd0},
    '{32'h8000_1234, 1'b0, 1'b1, 3'd0, 4'd0},
    '{32'hA000_0040, 1'b0, 1'b1, 3'd0, 4'd0},
    '{32'hE000_0000, 1'b1, 1'b1, 3'd4, 4'd0},
    '{32'hE000_0010, 1'b1, 1'b0, 3'd4, 4'd0},
    '{32'hFF00_0000, 1'b0, 1'b1, 3'd0, 4'd0},
    '{32'h0040_1234, 1'b0, 1'b1, 3'd0, 4'd1},
    '{32'h0040_1ABC, 1'b0, 1'b1, 3'd0, 4'd0},
    '{32'hC000_2000, 1'b0, 1'b1, 3'd0, 4'd1},
    '{32'h0040_1000, 1'b1, 1'b1, 3'd0, 4'd0},
    '{32'h7FFF_FFFC, 1'b1, 1'b1, 3'd0, 4'd1}
  };

  localparam logic [31:0] LRU_SEQ [12] = '{
    32'h0010_0000, 32'h0020_0000, 32'h0030_0000, 32'h0040_0000,
    32'h0010_0000, 32'h0050_0000, 32'h0010_0000, 32'h0030_0000,
    32'h0040_0000, 32'h0050_0000, 32'h0020_0000, 32'h0010_0000
  };
  localparam logic [11:0] LRU_REF = 12'b1100_0010_1111; // bit i = refill expected for step i

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_vaddr = '0;
  logic        mode_user = 1'b0;
  logic        xlat_on = 1'b0;
  logic        priv_skip_asid = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic [2:0]  res_status;
  logic        utlb_req;
  logic [31:0] utlb_vaddr;
  logic        utlb_resp_valid = 1'b0;
  logic [1:0]  utlb_resp_status = '0;
  logic [21:0] utlb_vpn = '0;
  logic [7:0]  utlb_asid = '0;
  logic [21:0] utlb_ppn = '0;
  logic [1:0]  utlb_size = '0;
  logic        utlb_shared = 1'b0;
  logic [1:0]  utlb_pr = '0;

  // Stand-in unified buffer configuration
  logic [1:0] u_status = 2'd0;
  logic [1:0] u_size = 2'd1;
  logic [1:0] u_pr = 2'd3;
  logic       u_shared = 1'b1;
  logic       u_wrong = 1'b0;

  int errors = 0;
  int checks = 0;
  int ureq_cnt = 0;
  logic [31:0] got_pa;
  logic [2:0]  got_st;
  int          got_ref, got_lat;

  itlb_top uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] map_pa(input logic [31:0] va, input logic [1:0] sz);
    logic [31:0] low;
    low = (sz == 2'd0) ? 32'h3FF : (sz == 2'd1) ? 32'hFFF : (sz == 2'd2) ? 32'hFFFF : 32'hFFFFF;
    return ({va[31:10] ^ KEY, 10'b0} & ~low) | (va & low);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fetch(input logic [31:0] va, input logic usr, input logic at,
                       input logic sv, input logic [7:0] asid);
    int snap;
    int cyc;
    @(negedge clk);
    fetch_vaddr = va; mode_user = usr; xlat_on = at; priv_skip_asid = sv; cur_asid = asid;
    fetch_valid = 1'b1;
    snap = ureq_cnt;
    @(negedge clk);
    fetch_valid = 1'b0;
    cyc = 1;
    while (!res_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    got_lat = cyc;
    got_pa  = res_paddr;
    got_st  = res_status;
    got_ref = ureq_cnt - snap;
    if (!res_valid) begin
      checks++;
      errors++;
      $display("FAIL R10 no result for va=0x%08h actual=timeout expected=res_valid", va);
    end
  endtask

  // Stand-in unified buffer: answers on the second cycle of a request
  initial begin
    int  wait_cnt;
    logic prev_req;
    wait_cnt = 0;
    prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if (utlb_req && !prev_req) ureq_cnt++;
      prev_req = utlb_req;
      if (utlb_req && wait_cnt == 1) begin
        utlb_resp_valid  = 1'b1;
        utlb_resp_status = u_status;
        utlb_vpn         = utlb_vaddr[31:10] ^ (u_wrong ? 22'h200000 : 22'h0);
        utlb_ppn         = utlb_vaddr[31:10] ^ KEY;
        utlb_asid        = cur_asid;
        utlb_size        = u_size;
        utlb_shared      = u_shared;
        utlb_pr          = u_pr;
        wait_cnt++;
      end else if (utlb_req) begin
        utlb_resp_valid = 1'b0;
        wait_cnt++;
      end else begin
        utlb_resp_valid = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R11 res_valid after reset", {31'b0, res_valid}, 32'd0);
    check("R11 utlb_req after reset", {31'b0, utlb_req}, 32'd0);
    check("R11 fetch_ready after reset", {31'b0, fetch_ready}, 32'd1);

    // Vector table: R1/R2/R3 with default 4 KiB, shared, executable entries
    for (int i = 0; i < 11; i++) begin
      logic [31:0] exp_pa;
      logic        byp;
      fetch(VEC[i].va, VEC[i].user, VEC[i].at, 1'b0, 8'h00);
      byp = !VEC[i].at || (VEC[i].va >= 32'h8000_0000 && VEC[i].va < 32'hC000_0000)
            || VEC[i].va >= 32'hE000_0000;
      exp_pa = (VEC[i].st != 3'd0) ? 32'h0 : (byp ? VEC[i].va : map_pa(VEC[i].va, 2'd1));
      check($sformatf("R1/R2/R3 row %0d status", i), {29'b0, got_st}, {29'b0, VEC[i].st});
      check($sformatf("R1/R2/R3 row %0d paddr", i), got_pa, exp_pa);
      check($sformatf("R1/R7 row %0d requests", i), got_ref, {28'b0, VEC[i].refills});
      if (i == 0) check("R10 bypass latency", got_lat, 32'd2);
    end

    // R8: eviction follows least-recent use
    do_reset();
    for (int i = 0; i < 12; i++) begin
      fetch(LRU_SEQ[i], 1'b0, 1'b1, 1'b0, 8'h00);
      check($sformatf("R8 step %0d requests", i), got_ref, {31'b0, LRU_REF[i]});
      check($sformatf("R8 step %0d status", i), {29'b0, got_st}, 32'd0);
    end

    // R3: 1 KiB and 64 KiB page sizes
    do_reset();
    u_size = 2'd0;
    fetch(32'h1234_5678, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R3 1K paddr", got_pa, map_pa(32'h1234_5678, 2'd0));
    u_size = 2'd2;
    fetch(32'h3456_789A, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R3 64K paddr", got_pa, map_pa(32'h3456_789A, 2'd2));
    fetch(32'h3456_0002, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R3 64K same page hit requests", got_ref, 32'd0);
    check("R3 64K same page paddr", got_pa, map_pa(32'h3456_0002, 2'd2));

    // R5: overlapping 4 KiB and 1 MiB entries
    do_reset();
    u_size = 2'd1;
    fetch(32'h0040_1000, 1'b0, 1'b1, 1'b0, 8'h00);
    u_size = 2'd3;
    fetch(32'h0041_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R5 1M refill paddr", got_pa, map_pa(32'h0041_0000, 2'd3));
    check("R5 1M refill requests", got_ref, 32'd1);
    fetch(32'h0040_1000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R5 multi-hit status", {29'b0, got_st}, 32'd2);
    check("R5 multi-hit requests", got_ref, 32'd0);
    u_size = 2'd1;

    // R6: failures from the unified buffer pass through, nothing stored
    do_reset();
    u_status = 2'd1;
    fetch(32'h00A0_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 miss status", {29'b0, got_st}, 32'd1);
    check("R6 miss paddr", got_pa, 32'd0);
    u_status = 2'd2;
    fetch(32'h00A0_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 multi status", {29'b0, got_st}, 32'd2);
    check("R6 multi requests (nothing stored)", got_ref, 32'd1);
    u_status = 2'd0;
    fetch(32'h00A0_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 later refill requests", got_ref, 32'd1);
    check("R6 later refill status", {29'b0, got_st}, 32'd0);

    // R7: a retry that still misses reports miss after one request
    do_reset();
    u_wrong = 1'b1;
    fetch(32'h0090_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R7 failed retry status", {29'b0, got_st}, 32'd1);
    check("R7 failed retry requests", got_ref, 32'd1);
    u_wrong = 1'b0;

    // R9: user fetch of a privileged-only page
    do_reset();
    u_pr = 2'd0;
    fetch(32'h0070_0000, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R9 privileged fetch status", {29'b0, got_st}, 32'd0);
    fetch(32'h0070_0000, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 user fetch status", {29'b0, got_st}, 32'd3);
    check("R9 user fetch requests", got_ref, 32'd0);
    u_pr = 2'd2;
    fetch(32'h0080_0000, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 user-executable status", {29'b0, got_st}, 32'd0);
    u_pr = 2'd3;

    // R4: identifier rules
    do_reset();
    u_shared = 1'b0;
    fetch(32'h0060_0000, 1'b1, 1'b1, 1'b0, 8'd5);
    check("R4 first fetch requests", got_ref, 32'd1);
    fetch(32'h0060_0000, 1'b1, 1'b1, 1'b0, 8'd5);
    check("R4 same id hit requests", got_ref, 32'd0);
    fetch(32'h0060_0000, 1'b1, 1'b1, 1'b0, 8'd7);
    check("R4 other id requests", got_ref, 32'd1);
    fetch(32'h0060_0000, 1'b0, 1'b1, 1'b1, 8'd9);
    check("R4 privileged skip gives multi", {29'b0, got_st}, 32'd2);
    fetch(32'h0060_0000, 1'b0, 1'b1, 1'b0, 8'd5);
    check("R4 privileged compare status", {29'b0, got_st}, 32'd0);
    check("R4 privileged compare requests", got_ref, 32'd0);
    check("R4 privileged compare paddr", got_pa, map_pa(32'h0060_0000, 2'd1));
    u_shared = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule